// File: doc/BRIEF.md
# Address Entry Allocation Scan Engine

This engine decides which slot of an address lookup table should receive a new unicast or multicast address entry. A one-cycle `start` pulse loads a 48-bit MAC address. The engine then reads table slots in ascending order, one per clock, through a synchronous read port. Read data returns one cycle after the request.

Each returned slot is classified from its type fields. The engine picks a slot in this order of preference:
1. A slot that already holds the same address.
2. Otherwise, the lowest-numbered empty slot.
3. Otherwise, the lowest-numbered learned unicast slot that may be aged out.

The lowest empty and lowest ageable positions are both recorded during a single pass. An address hit ends the scan at once. When no slot qualifies, a fail indication is raised with `done`. Writing the new entry is left to the caller, which receives the chosen index and the reason it was chosen.

Top module: `slot_pick_top`

## Requirements
- R1: Slot type is read from bits 61:60 (0 empty, 1 address, 2 VLAN, 3 VLAN+address). Only types 1 and 3 are compared against the search address, and only they can be ageable. A type 2 slot never matches and is never chosen.
- R2: A slot's address is bits 47:0. Search byte 0 (the first byte on the wire) is bits 47:40 and byte 5 is bits 7:0. The match is an exact 48-bit compare.
- R3: An address hit wins over any empty or ageable slot at a lower index. The result kind is 1 and the index is the hit slot.
- R4: With no hit, the lowest empty slot (type 0) is chosen with kind 2, even when an ageable slot has a lower index.
- R5: With no hit and no empty slot, the lowest ageable slot is chosen with kind 3. A slot is ageable when its type is 1 or 3, bit 40 is 0, and its unicast class in bits 63:62 is 1 (untouched) or 3 (touched).
- R6: A slot whose bit 40 is set (multicast), or whose unicast class is 0 (persistent) or 2 (OUI), is never ageable.
- R7: When no slot qualifies, `fail` is 1 and the kind is 0 at `done`. Otherwise `fail` is 0. Kind and index hold until the next `done`.
- R8: After `start` is accepted on clock edge E, `rdEn` is high with `rdIdx` = 0 after E. `rdIdx` then rises by one per cycle. `rdEntry` must present slot `rdIdx` one cycle after the request. A scan with no hit issues exactly NUM_ENTRIES reads.
- R9: `done` is high for exactly one cycle. If k is the last slot examined (the hit slot, or NUM_ENTRIES-1 when there is no hit), `done` goes high after edge E+k+2.
- R10: A `start` pulse that arrives while a scan is running is ignored. It does not restart the reads, change the result or change the latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search (accepted only when idle) |
| macIn | input | 48 | Address to search, captured with start |
| rdEntry | input | ENTRY_W | Table read data, one cycle after the request |
| rdEn | output | 1 | Table read request |
| rdIdx | output | clog2(NUM_ENTRIES) | Table read slot index |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | No slot qualified |
| chosenIdx | output | clog2(NUM_ENTRIES) | Selected slot |
| chosenKind | output | 2 | 0 none, 1 address hit, 2 empty, 3 ageable |

## Verification
The hardest situation to reach is the third tier. It needs a table with no empty slot and no hit, in which ageable candidates sit between persistent, OUI, multicast and VLAN-only slots. The bench fills the modelled table with distinct persistent unicast slots and then plants a few candidates, so that the lowest qualifying index differs from the lowest index carrying any touched or untouched mark. Hit-versus-empty priority and mid-scan start pulses are staged the same way. Read ordering and latency are measured against the counted edges.

// File: rtl/slot_pick_pkg.sv
package slot_pick_pkg;
  localparam int MAC_W     = 48;
  localparam int TYPE_LO   = 60;
  localparam int UCLASS_LO = 62;
  localparam int GROUP_BIT = 40;

  typedef enum logic [1:0] {
    ET_EMPTY     = 2'd0,
    ET_ADDR      = 2'd1,
    ET_VLAN      = 2'd2,
    ET_VLAN_ADDR = 2'd3
  } slotType_t;

  typedef enum logic [1:0] {
    UC_PERSIST   = 2'd0,
    UC_UNTOUCHED = 2'd1,
    UC_OUI       = 2'd2,
    UC_TOUCHED   = 2'd3
  } uClass_t;

  typedef enum logic [1:0] {
    PK_NONE  = 2'd0,
    PK_MATCH = 2'd1,
    PK_EMPTY = 2'd2,
    PK_AGE   = 2'd3
  } pickKind_t;

  typedef struct packed {
    logic clearTrack;
    logic latchMac;
    logic evalEn;
    logic commit;
  } ctlStrobe_t;
endpackage

// File: rtl/slot_entry_decode.sv
module slot_entry_decode
  import slot_pick_pkg::*;
#(
  parameter int ENTRY_W = 68
) (
  input  logic [ENTRY_W-1:0] entry,
  input  logic [MAC_W-1:0]   mac,
  output logic               isEmpty,
  output logic               isAgeable,
  output logic               addrHit
);
  slotType_t sType;
  uClass_t   uClass;
  logic      isAddr;
  logic      isGroup;

  always_comb begin
    sType     = slotType_t'(entry[TYPE_LO+1:TYPE_LO]);
    uClass    = uClass_t'(entry[UCLASS_LO+1:UCLASS_LO]);
    isGroup   = entry[GROUP_BIT];
    isAddr    = (sType == ET_ADDR) || (sType == ET_VLAN_ADDR);
    isEmpty   = (sType == ET_EMPTY);
    addrHit   = isAddr && (entry[MAC_W-1:0] == mac);
    isAgeable = isAddr && !isGroup &&
                ((uClass == UC_UNTOUCHED) || (uClass == UC_TOUCHED));
  end
endmodule

// File: rtl/slot_pick_ctl.sv
module slot_pick_ctl
  import slot_pick_pkg::*;
#(
  parameter int NUM_ENTRIES = 32,
  parameter int IDX_W       = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             addrHit,
  output logic             busy,
  output logic             rdEn,
  output logic [IDX_W-1:0] rdIdx,
  output logic [IDX_W-1:0] evalIdx,
  output logic             done,
  output ctlStrobe_t       strobe
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

  typedef enum logic {ST_IDLE, ST_SCAN} state_t;

  state_t state;
  logic   evalPend;
  logic   accept;
  logic   finish;

  always_comb begin
    busy              = (state == ST_SCAN);
    accept            = (state == ST_IDLE) && start;
    finish            = busy && evalPend && (addrHit || (evalIdx == LAST_IDX));
    strobe.clearTrack = accept;
    strobe.latchMac   = accept;
    strobe.evalEn     = busy && evalPend;
    strobe.commit     = finish;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      rdEn     <= 1'b0;
      rdIdx    <= '0;
      evalPend <= 1'b0;
      evalIdx  <= '0;
      done     <= 1'b0;
    end else begin
      done     <= 1'b0;
      evalPend <= rdEn;
      evalIdx  <= rdIdx;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_SCAN;
            rdEn  <= 1'b1;
            rdIdx <= '0;
          end
        end
        ST_SCAN: begin
          if (rdEn) begin
            if (rdIdx == LAST_IDX) rdEn <= 1'b0;
            else                   rdIdx <= rdIdx + 1'b1;
          end
          if (finish) begin
            state <= ST_IDLE;
            rdEn  <= 1'b0;
            done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/slot_pick_datapath.sv
module slot_pick_datapath
  import slot_pick_pkg::*;
#(
  parameter int ENTRY_W = 68,
  parameter int IDX_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ctlStrobe_t         strobe,
  input  logic [MAC_W-1:0]   macIn,
  input  logic [ENTRY_W-1:0] rdEntry,
  input  logic [IDX_W-1:0]   evalIdx,
  output logic               addrHit,
  output logic [IDX_W-1:0]   chosenIdx,
  output logic [1:0]         chosenKind,
  output logic               fail
);
  logic [MAC_W-1:0] macReg;
  logic             emptySeen, ageSeen;
  logic [IDX_W-1:0] emptyIdx, ageIdx;
  logic             curEmpty, curAgeable;
  logic             emptyAny, ageAny;
  logic [IDX_W-1:0] emptySel, ageSel;

  slot_entry_decode #(.ENTRY_W(ENTRY_W)) u_dec (
    .entry    (rdEntry),
    .mac      (macReg),
    .isEmpty  (curEmpty),
    .isAgeable(curAgeable),
    .addrHit  (addrHit)
  );

  always_comb begin
    emptyAny = emptySeen || (strobe.evalEn && curEmpty);
    emptySel = emptySeen ? emptyIdx : evalIdx;
    ageAny   = ageSeen || (strobe.evalEn && curAgeable);
    ageSel   = ageSeen ? ageIdx : evalIdx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      macReg     <= '0;
      emptySeen  <= 1'b0;
      emptyIdx   <= '0;
      ageSeen    <= 1'b0;
      ageIdx     <= '0;
      chosenIdx  <= '0;
      chosenKind <= PK_NONE;
      fail       <= 1'b0;
    end else begin
      if (strobe.latchMac) macReg <= macIn;
      if (strobe.clearTrack) begin
        emptySeen <= 1'b0;
        ageSeen   <= 1'b0;
      end else if (strobe.evalEn) begin
        if (curEmpty && !emptySeen) begin
          emptySeen <= 1'b1;
          emptyIdx  <= evalIdx;
        end
        if (curAgeable && !ageSeen) begin
          ageSeen <= 1'b1;
          ageIdx  <= evalIdx;
        end
      end
      if (strobe.commit) begin
        fail <= 1'b0;
        if (addrHit) begin
          chosenKind <= PK_MATCH;
          chosenIdx  <= evalIdx;
        end else if (emptyAny) begin
          chosenKind <= PK_EMPTY;
          chosenIdx  <= emptySel;
        end else if (ageAny) begin
          chosenKind <= PK_AGE;
          chosenIdx  <= ageSel;
        end else begin
          chosenKind <= PK_NONE;
          chosenIdx  <= '0;
          fail       <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/slot_pick_top.sv
module slot_pick_top
  import slot_pick_pkg::*;
#(
  parameter int NUM_ENTRIES = 32,
  parameter int ENTRY_W     = 68
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic [47:0]                    macIn,
  input  logic [ENTRY_W-1:0]             rdEntry,
  output logic                           rdEn,
  output logic [$clog2(NUM_ENTRIES)-1:0] rdIdx,
  output logic                           done,
  output logic                           fail,
  output logic [$clog2(NUM_ENTRIES)-1:0] chosenIdx,
  output logic [1:0]                     chosenKind
);
  localparam int IDX_W = $clog2(NUM_ENTRIES);

  ctlStrobe_t       strobe;
  logic             addrHit;
  logic             busy;
  logic [IDX_W-1:0] evalIdx;

  slot_pick_ctl #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_ctl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .addrHit(addrHit),
    .busy   (busy),
    .rdEn   (rdEn),
    .rdIdx  (rdIdx),
    .evalIdx(evalIdx),
    .done   (done),
    .strobe (strobe)
  );

  slot_pick_datapath #(.ENTRY_W(ENTRY_W), .IDX_W(IDX_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .macIn     (macIn),
    .rdEntry   (rdEntry),
    .evalIdx   (evalIdx),
    .addrHit   (addrHit),
    .chosenIdx (chosenIdx),
    .chosenKind(chosenKind),
    .fail      (fail)
  );
endmodule

// File: rtl/slot_pick_checker.sv
module slot_pick_checker #(
  parameter int NUM_ENTRIES = 32,
  parameter int IDX_W       = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             rdEn,
  input logic [IDX_W-1:0] rdIdx,
  input logic             done,
  input logic             fail,
  input logic [1:0]       chosenKind
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_DONE_ENDS_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy)); // R9

  AST_FAIL_MEANS_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fail == (chosenKind == 2'd0))); // R7

  AST_READ_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (rdEn && (rdIdx == '0))); // R8

  AST_READ_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && $past(rdEn)) |-> (rdIdx == IDX_W'($past(rdIdx) + 1'b1))); // R8

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rdEn && (rdIdx != LAST_IDX)) |=> (rdIdx != '0)); // R10
endmodule

bind slot_pick_top slot_pick_checker #(
  .NUM_ENTRIES(NUM_ENTRIES),
  .IDX_W      ($clog2(NUM_ENTRIES))
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .rdEn      (rdEn),
  .rdIdx     (rdIdx),
  .done      (done),
  .fail      (fail),
  .chosenKind(chosenKind)
);

// File: tb/sim_slot_pick_top.sv
`timescale 1ns/1ps
module sim_slot_pick_top;
  localparam int N  = 16;
  localparam int EW = 68;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [47:0]   macIn = '0;
  logic [EW-1:0] rdEntry = '0;
  logic          rdEn, done, fail;
  logic [IW-1:0] rdIdx, chosenIdx;
  logic [1:0]    chosenKind;

  logic [EW-1:0] mem [N];

  int checks = 0;
  int fails  = 0;
  int expRd  = 0;
  int rdCnt  = 0;
  int rdErr  = 0;

  always #2.5 clk = ~clk;

  slot_pick_top #(.NUM_ENTRIES(N), .ENTRY_W(EW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .macIn(macIn), .rdEntry(rdEntry),
    .rdEn(rdEn), .rdIdx(rdIdx), .done(done), .fail(fail),
    .chosenIdx(chosenIdx), .chosenKind(chosenKind)
  );

  always_ff @(posedge clk) if (rdEn) rdEntry <= mem[rdIdx];

  always @(negedge clk) begin
    if (rdEn) begin
      if (int'(rdIdx) != expRd) rdErr++;
      expRd++;
      rdCnt++;
    end
  end

  task automatic chkEq(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [EW-1:0] mkEntry(logic [1:0] st, logic [1:0] uc, logic [47:0] mac);
    return {4'h0, uc, st, 12'h000, mac};
  endfunction

  function automatic logic [47:0] uniMac(int i);
    return 48'hA0_00_00_00_10_00 + 48'(i);
  endfunction

  task automatic fillTable(logic [1:0] st, logic [1:0] uc);
    for (int i = 0; i < N; i++) mem[i] = mkEntry(st, uc, uniMac(i));
  endtask

  task automatic runSearch(string req, logic [47:0] mac, int expKind, int expIdx,
                           int expLat, int expReads, bit midStart);
    int cnt;
    expRd = 0; rdCnt = 0; rdErr = 0;
    @(negedge clk); macIn = mac; start = 1'b1;
    @(negedge clk); start = 1'b0;
    cnt = 0;
    while (!done && cnt < N + 20) begin
      @(negedge clk);
      cnt++;
      start = (midStart && cnt == 3) ? 1'b1 : 1'b0;
    end
    start = 1'b0;
    chkEq(req, "done latency", cnt, expLat);
    chkEq(req, "kind", chosenKind, expKind);
    chkEq(req, "index", chosenIdx, expIdx);
    chkEq(req, "fail", fail, (expKind == 0));
    @(negedge clk);
    chkEq("R9", "done width", done, 0);
    chkEq("R7", "kind held", chosenKind, expKind);
    chkEq("R8", "read order errors", rdErr, 0);
    if (expReads >= 0) chkEq(req, "read count", rdCnt, expReads);
  endtask

  // R3: hit beats a lower empty slot
  task automatic testHitPriority();
    logic [47:0] m = 48'h02_11_22_33_44_55;
    fillTable(2'd2, 2'd0);
    mem[2] = mkEntry(2'd0, 2'd0, uniMac(2));
    mem[9] = mkEntry(2'd1, 2'd0, m);
    runSearch("R3", m, 1, 9, 11, -1, 0);
    mem[0] = mkEntry(2'd1, 2'd3, m);
    runSearch("R3", m, 1, 0, 2, -1, 0);
  endtask

  // R1: type 2 never matches or ages, type 3 matches
  task automatic testTypeFilter();
    logic [47:0] m = 48'h04_AB_CD_EF_01_23;
    for (int i = 0; i < N; i++) mem[i] = mkEntry(2'd2, 2'd3, m);
    mem[7]  = mkEntry(2'd3, 2'd0, m);
    mem[12] = mkEntry(2'd0, 2'd0, m);
    runSearch("R1", m, 1, 7, 9, -1, 0);
    for (int i = 0; i < N; i++) mem[i] = mkEntry(2'd2, 2'd3, m);
    runSearch("R1", m, 0, 0, N + 1, N, 0);
  endtask

  // R2: byte order of the address field
  task automatic testByteOrder();
    logic [47:0] m  = 48'h02_11_22_33_44_56;
    logic [47:0] sw = 48'h56_44_33_22_11_02;
    fillTable(2'd1, 2'd0);
    mem[1] = mkEntry(2'd1, 2'd0, sw);
    mem[5] = mkEntry(2'd1, 2'd0, m);
    runSearch("R2", m, 1, 5, 7, -1, 0);
    runSearch("R2", sw, 1, 1, 3, -1, 0);
  endtask

  // R4: lowest empty, even past a lower ageable
  task automatic testEmpty();
    fillTable(2'd0, 2'd0);
    runSearch("R4", 48'h0A_0B_0C_0D_0E_0F, 2, 0, N + 1, N, 0);
    fillTable(2'd1, 2'd0);
    mem[1]  = mkEntry(2'd1, 2'd3, uniMac(1));
    mem[4]  = mkEntry(2'd0, 2'd0, uniMac(4));
    mem[11] = mkEntry(2'd0, 2'd0, uniMac(11));
    runSearch("R4", 48'h0A_0B_0C_0D_0E_0F, 2, 4, N + 1, N, 0);
    fillTable(2'd1, 2'd0);
    mem[N-1] = mkEntry(2'd0, 2'd0, uniMac(N - 1));
    runSearch("R4", 48'h0A_0B_0C_0D_0E_0F, 2, N - 1, N + 1, N, 0);
  endtask

  // R5: lowest ageable unicast
  task automatic testAgeable();
    fillTable(2'd1, 2'd0);
    mem[3] = mkEntry(2'd1, 2'd2, uniMac(3));
    mem[6] = mkEntry(2'd1, 2'd3, uniMac(6));
    mem[9] = mkEntry(2'd1, 2'd1, uniMac(9));
    runSearch("R5", 48'h0C_00_00_00_00_01, 3, 6, N + 1, N, 0);
    mem[6] = mkEntry(2'd1, 2'd0, uniMac(6));
    runSearch("R5", 48'h0C_00_00_00_00_01, 3, 9, N + 1, N, 0);
  endtask

  // R6/R7: multicast and persistent/OUI are never ageable
  task automatic testGroupAndFail();
    fillTable(2'd1, 2'd0);
    mem[2] = mkEntry(2'd1, 2'd3, 48'h01_00_5E_00_00_07);
    mem[5] = mkEntry(2'd1, 2'd2, uniMac(5));
    mem[8] = mkEntry(2'd3, 2'd1, uniMac(8));
    runSearch("R6", 48'h0C_00_00_00_00_02, 3, 8, N + 1, N, 0);
    mem[8] = mkEntry(2'd3, 2'd2, uniMac(8));
    runSearch("R7", 48'h0C_00_00_00_00_02, 0, 0, N + 1, N, 0);
  endtask

  // R10: start while busy is ignored
  task automatic testBusyStart();
    fillTable(2'd1, 2'd0);
    mem[13] = mkEntry(2'd0, 2'd0, uniMac(13));
    runSearch("R10", 48'h0E_00_00_00_00_03, 2, 13, N + 1, N, 1);
    mem[6] = mkEntry(2'd1, 2'd0, 48'h0E_00_00_00_00_03);
    runSearch("R10", 48'h0E_00_00_00_00_03, 1, 6, 8, -1, 1);
  endtask

  initial begin
    fillTable(2'd0, 2'd0);
    repeat (4) @(negedge clk);
    chkEq("R9", "reset done", done, 0);
    chkEq("R8", "reset rdEn", rdEn, 0);
    chkEq("R7", "reset fail", fail, 0);
    chkEq("R7", "reset kind", chosenKind, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    testEmpty();
    testHitPriority();
    testTypeFilter();
    testByteOrder();
    testAgeable();
    testGroupAndFail();
    testBusyStart();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule